// File: doc/BRIEF.md
# Aging Reorder Request Scheduler

This block keeps up to eight pending memory burst requests and decides which one goes out next. With reordering switched on it favours requests flagged as hitting an already-open row, which lets a younger request overtake older ones. This is done to gain bandwidth. With reordering switched off the queue behaves as a plain FIFO.

Every waiting request keeps a count of how many bursts were issued ahead of it. When that count reaches a programmable 6-bit threshold, the request is treated as starving. A starving request wins over every request that is not starving. If several requests are starving, the oldest of them wins. A threshold of zero marks every request as starving at once, so the queue then issues in arrival order.

Requests enter through a valid/ready port that carries an address and a row-hit flag. Grants leave through a valid/ready issue port. Timing rules for the memory and command encoding belong to other blocks.

Top module: `reorder_sched`

## Requirements
- R1: After a synchronous reset the issue port shows no request (iss_valid = 0) and the request port is ready (req_ready = 1).
- R2: The queue holds 8 requests. req_ready is low while 8 are held, and a request offered while full is not stored. An accepted request is visible on the issue port in the cycle after the clock edge that accepted it.
- R3: With cfg_reorder_en = 0, requests issue in arrival order whatever their row-hit flags.
- R4: With cfg_reorder_en = 1 and no request starving, the oldest request with req_row_hit = 1 issues first. If no queued request has the flag set, the oldest request issues.
- R5: Each queued request counts the bursts issued ahead of it, meaning issues of younger requests. The request becomes starving once its count is greater than or equal to cfg_starve_limit. With a limit of 63, a request overtaken 63 times issues next.
- R6: A starving request issues ahead of row-hit requests. A request that arrives later starts with a count of zero.
- R7: When several requests are starving, the oldest starving request issues first.
- R8: With cfg_starve_limit = 0, requests issue in arrival order even when reordering is enabled.
- R9: While iss_valid = 1 and iss_ready = 0, with no new request offered and the configuration unchanged, iss_addr and iss_row_hit hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reorder_en | input | 1 | Allows out-of-order issue when 1 |
| cfg_starve_limit | input | 6 | Overtake count at which a request is promoted |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Queue can accept a request |
| req_addr | input | 32 | Address of incoming request |
| req_row_hit | input | 1 | Incoming request hits an open row |
| iss_valid | output | 1 | A request is offered for issue |
| iss_ready | input | 1 | Downstream takes the offered request |
| iss_addr | output | 32 | Address of offered request |
| iss_row_hit | output | 1 | Row-hit flag of offered request |

## Verification
A corrupted age position shows up on the issue port at the next grant as an out-of-order address. The directed drains compare every grant address in turn, so such a fault is caught on the first wrong issue. An overtake counter that does not increment, or that fails to clear, changes the moment a starving request is promoted. The long 63-overtake stream pins that moment down to the exact cycle. An occupancy error shows at once as a wrong req_ready or iss_valid, and the checker's own handshake count flags it on the same edge.

// File: rtl/rsched_pkg.sv
package rsched_pkg;

    localparam int QDEPTH  = 8;
    localparam int ADDR_W  = 32;
    localparam int CNT_W   = 6;
    localparam int IDX_W   = $clog2(QDEPTH);
    localparam int OCC_W   = $clog2(QDEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              row_hit;
        logic [CNT_W-1:0]  skips;
    } rs_entry_t;

    typedef enum logic [1:0] {
        PICK_HEAD,
        PICK_STARVED,
        PICK_ROWHIT
    } rs_pick_kind_e;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] lowest_set(input logic [QDEPTH-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = QDEPTH - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/rsched_queue.sv
module rsched_queue
    import rsched_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  rs_entry_t             push_ent,
    input  logic                  pop,
    input  logic [IDX_W-1:0]      pop_idx,
    output rs_entry_t             slots [QDEPTH],
    output logic [QDEPTH-1:0]     occupied,
    output logic [OCC_W-1:0]      fill
);

    rs_entry_t        mem   [QDEPTH];
    rs_entry_t        above [QDEPTH];
    rs_entry_t        nxt   [QDEPTH];
    logic [OCC_W-1:0] fill_q;
    logic [OCC_W-1:0] tail;

    // Each slot's upper neighbour, used to close the gap left by a pop.
    genvar g;
    generate
        for (g = 0; g < QDEPTH; g++) begin : g_above
            if (g == QDEPTH - 1) begin : g_top
                assign above[g] = '0;
            end else begin : g_mid
                assign above[g] = mem[g + 1];
            end
            assign slots[g]    = mem[g];
            assign occupied[g] = (OCC_W'(g) < fill_q);
        end
    endgenerate

    assign fill = fill_q;
    assign tail = fill_q - OCC_W'(pop);

    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            nxt[i] = mem[i];
            if (pop) begin
                if (IDX_W'(i) < pop_idx) begin
                    // Older than the issued entry: it was overtaken.
                    nxt[i].skips = sat_inc(mem[i].skips);
                end else begin
                    nxt[i] = above[i];
                end
            end
        end
        if (push) begin
            nxt[tail[IDX_W-1:0]] = push_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            for (int i = 0; i < QDEPTH; i++) mem[i] <= '0;
        end else begin
            fill_q <= fill_q + OCC_W'(push) - OCC_W'(pop);
            for (int i = 0; i < QDEPTH; i++) mem[i] <= nxt[i];
        end
    end

endmodule

// File: rtl/rsched_pick.sv
module rsched_pick
    import rsched_pkg::*;
(
    input  rs_entry_t           slots [QDEPTH],
    input  logic [QDEPTH-1:0]   occupied,
    input  logic                reorder_en,
    input  logic [CNT_W-1:0]    starve_limit,
    output logic [IDX_W-1:0]    pick_idx,
    output rs_pick_kind_e       pick_kind
);

    logic [QDEPTH-1:0] starving;
    logic [QDEPTH-1:0] hitting;

    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            starving[i] = occupied[i] && (slots[i].skips >= starve_limit);
            hitting[i]  = occupied[i] && slots[i].row_hit;
        end
        pick_idx  = '0;
        pick_kind = PICK_HEAD;
        if (reorder_en) begin
            if (|starving) begin
                pick_idx  = lowest_set(starving);
                pick_kind = PICK_STARVED;
            end else if (|hitting) begin
                pick_idx  = lowest_set(hitting);
                pick_kind = PICK_ROWHIT;
            end
        end
    end

endmodule

// File: rtl/reorder_sched.sv
module reorder_sched
    import rsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_reorder_en,
    input  logic [CNT_W-1:0]  cfg_starve_limit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_row_hit,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [ADDR_W-1:0] iss_addr,
    output logic              iss_row_hit
);

    rs_entry_t         slots [QDEPTH];
    rs_entry_t         new_ent;
    logic [QDEPTH-1:0] occupied;
    logic [OCC_W-1:0]  fill;
    logic [IDX_W-1:0]  pick_idx;
    rs_pick_kind_e     pick_kind;
    logic              push;
    logic              pop;

    assign req_ready = (fill < OCC_W'(QDEPTH));
    assign iss_valid = (fill != '0);
    assign push      = req_valid && req_ready;
    assign pop       = iss_valid && iss_ready;

    assign new_ent.addr    = req_addr;
    assign new_ent.row_hit = req_row_hit;
    assign new_ent.skips   = '0;

    rsched_queue u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (new_ent),
        .pop      (pop),
        .pop_idx  (pick_idx),
        .slots    (slots),
        .occupied (occupied),
        .fill     (fill)
    );

    rsched_pick u_pick (
        .slots        (slots),
        .occupied     (occupied),
        .reorder_en   (cfg_reorder_en),
        .starve_limit (cfg_starve_limit),
        .pick_idx     (pick_idx),
        .pick_kind    (pick_kind)
    );

    assign iss_addr    = slots[pick_idx].addr;
    assign iss_row_hit = slots[pick_idx].row_hit;

endmodule

// File: rtl/rsched_checker.sv
module rsched_checker
    import rsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_reorder_en,
    input  logic [CNT_W-1:0]  cfg_starve_limit,
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic              iss_valid,
    input  logic              iss_ready,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              iss_row_hit,
    input  logic [IDX_W-1:0]  pick_idx
);

    logic [OCC_W-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + OCC_W'(req_valid && req_ready) - OCC_W'(iss_valid && iss_ready);
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (!iss_valid && req_ready));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (req_ready == (occ < OCC_W'(QDEPTH))) && (iss_valid == (occ != '0)));

    assert_fifo_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_reorder_en && iss_valid) |-> (pick_idx == '0));

    assert_zero_limit_R8: assert property (@(posedge clk) disable iff (rst)
        ((cfg_starve_limit == '0) && iss_valid) |-> (pick_idx == '0));

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !req_valid) |=>
            (!$stable(cfg_reorder_en) || !$stable(cfg_starve_limit) ||
             ($stable(iss_addr) && $stable(iss_row_hit))));

endmodule

bind reorder_sched rsched_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .cfg_reorder_en   (cfg_reorder_en),
    .cfg_starve_limit (cfg_starve_limit),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .iss_valid        (iss_valid),
    .iss_ready        (iss_ready),
    .iss_addr         (iss_addr),
    .iss_row_hit      (iss_row_hit),
    .pick_idx         (pick_idx)
);

// File: tb/sim_reorder_sched.sv
module sim_reorder_sched;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_reorder_en = 1'b0;
    logic [5:0]  cfg_starve_limit = 6'd63;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_row_hit = 1'b0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [31:0] iss_addr;
    logic        iss_row_hit;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [31:0] exq [8];

    always #10 clk = ~clk;

    reorder_sched u0 (
        .clk(clk), .rst(rst),
        .cfg_reorder_en(cfg_reorder_en), .cfg_starve_limit(cfg_starve_limit),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_row_hit(req_row_hit),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_addr(iss_addr), .iss_row_hit(iss_row_hit)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic push(input logic [31:0] a, input logic h);
        req_valid = 1'b1; req_addr = a; req_row_hit = h;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain(input int n, input string req);
        iss_ready = 1'b1;
        for (int k = 0; k < n; k++) begin
            chk(iss_valid && iss_addr == exq[k], req, iss_addr, exq[k]);
            @(negedge clk);
        end
        iss_ready = 1'b0;
        chk(!iss_valid, req, {31'd0, iss_valid}, 32'd0);
    endtask

    task automatic t_reset_R1();
        chk(!iss_valid, "R1", {31'd0, iss_valid}, 32'd0);
        chk(req_ready, "R1", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_capacity_R2();
        cfg_reorder_en = 1'b0;
        push(32'h70, 1'b0);
        chk(iss_valid && iss_addr == 32'h70, "R2 latency", iss_addr, 32'h70);
        for (int k = 1; k < 8; k++) push(32'h70 + k, k[0]);
        chk(!req_ready, "R2 full", {31'd0, req_ready}, 32'd0);
        push(32'h78, 1'b1);
        chk(!req_ready, "R2 full", {31'd0, req_ready}, 32'd0);
        for (int k = 0; k < 8; k++) exq[k] = 32'h70 + k;
        drain(8, "R2 drop");
    endtask

    task automatic t_inorder_R3();
        cfg_reorder_en = 1'b0;
        push(32'h10, 1'b0); push(32'h11, 1'b1); push(32'h12, 1'b1); push(32'h13, 1'b0);
        exq[0] = 32'h10; exq[1] = 32'h11; exq[2] = 32'h12; exq[3] = 32'h13;
        drain(4, "R3");
    endtask

    task automatic t_rowhit_R4();
        cfg_reorder_en = 1'b1; cfg_starve_limit = 6'd63;
        push(32'h20, 1'b0); push(32'h21, 1'b1); push(32'h22, 1'b0); push(32'h23, 1'b1);
        exq[0] = 32'h21; exq[1] = 32'h23; exq[2] = 32'h20; exq[3] = 32'h22;
        drain(4, "R4");
        push(32'h24, 1'b0); push(32'h25, 1'b0);
        exq[0] = 32'h24; exq[1] = 32'h25;
        drain(2, "R4 no hit");
    endtask

    task automatic t_promote_R6();
        cfg_reorder_en = 1'b1; cfg_starve_limit = 6'd2;
        push(32'h30, 1'b0); push(32'h31, 1'b1); push(32'h32, 1'b1);
        push(32'h33, 1'b1); push(32'h34, 1'b0);
        // 0x30 is overtaken twice, then beats hit 0x33; 0x34 arrived later at zero.
        exq[0] = 32'h31; exq[1] = 32'h32; exq[2] = 32'h30; exq[3] = 32'h33; exq[4] = 32'h34;
        drain(5, "R6");
    endtask

    task automatic t_oldest_starved_R7();
        cfg_reorder_en = 1'b1; cfg_starve_limit = 6'd1;
        push(32'h40, 1'b0); push(32'h41, 1'b0); push(32'h42, 1'b1);
        exq[0] = 32'h42; exq[1] = 32'h40; exq[2] = 32'h41;
        drain(3, "R7");
    endtask

    task automatic t_zero_limit_R8();
        cfg_reorder_en = 1'b1; cfg_starve_limit = 6'd0;
        push(32'h50, 1'b0); push(32'h51, 1'b1); push(32'h52, 1'b1);
        exq[0] = 32'h50; exq[1] = 32'h51; exq[2] = 32'h52;
        drain(3, "R8");
    endtask

    task automatic t_hold_R9();
        cfg_reorder_en = 1'b1; cfg_starve_limit = 6'd63;
        push(32'h80, 1'b0); push(32'h81, 1'b0);
        for (int k = 0; k < 3; k++) begin
            chk(iss_valid && iss_addr == 32'h80, "R9", iss_addr, 32'h80);
            @(negedge clk);
        end
        push(32'h82, 1'b1);
        chk(iss_addr == 32'h82 && iss_row_hit, "R4 late hit", iss_addr, 32'h82);
        exq[0] = 32'h82; exq[1] = 32'h80; exq[2] = 32'h81;
        drain(3, "R9");
    endtask

    task automatic t_limit63_R5();
        cfg_reorder_en = 1'b1; cfg_starve_limit = 6'd63;
        push(32'h900, 1'b0); push(32'h1001, 1'b1);
        iss_ready = 1'b1;
        for (int k = 1; k <= 64; k++) begin
            logic [31:0] e;
            e = (k <= 63) ? (32'h1000 + k) : 32'h900;
            chk(iss_valid && iss_addr == e, "R5", iss_addr, e);
            if (k < 64) begin
                req_valid = 1'b1; req_addr = 32'h1000 + k + 1; req_row_hit = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        exq[0] = 32'h1040;
        drain(1, "R5 tail");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_R1();
        t_capacity_R2();
        t_inorder_R3();
        t_rowhit_R4();
        t_promote_R6();
        t_oldest_starved_R7();
        t_zero_limit_R8();
        t_hold_R9();
        t_limit63_R5();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule